// File: doc/BRIEF.md
# Serial Command Decoder with Write Arm Latch

This block is the serial front end of a battery-management device. It works as a slave on a four-wire serial bus in mode 0. While chip select is low, it takes in an 8-bit opcode, most significant bit first. The opcode decides how many address or payload bytes follow. It also decides whether the block then drives read data back on `miso`.

All inputs are brought into the system clock domain through a synchronizer, so every action happens on the `clk` edge.

Before any write changes storage, a write arm latch must be set. Only a separate one-byte arm frame sets it. A write is buffered during the frame and applied only when chip select rises after exactly the right number of bits. Applying the write also clears the latch. The storage behind the decoder is:
- a 512-byte memory held in flip-flops;
- two 16-bit words, a configuration word and a control word, driven out of the block as ports;
- a 4-bit lock field, which can be read back through a status byte.

The decoder is a single state machine with these states and transitions:
- `ST_IDLE`: chip select is high. It moves to `ST_OPCODE` once chip select is seen low.
- `ST_OPCODE`: collects the first byte, then goes to one of the following:
  - `ST_CMD_ONLY` for arm or disarm;
  - `ST_ADDR_HI` for a memory write or read;
  - `ST_PAYLOAD` for the configuration, control and lock writes;
  - `ST_READOUT` for the two status reads;
  - `ST_IGNORE` for any other code.
- `ST_ADDR_HI` goes to `ST_ADDR_LO` after one byte.
- `ST_ADDR_LO` goes to `ST_READOUT` for a read, or to `ST_PAYLOAD` for a write.
- `ST_PAYLOAD` goes to `ST_COMPLETE` after its last payload byte.
- `ST_COMPLETE` and `ST_CMD_ONLY` go to `ST_OVERRUN` on any further clock.
- `ST_READOUT`, `ST_OVERRUN` and `ST_IGNORE` hold until the frame ends.
- From every state, chip select high returns the machine to `ST_IDLE`. At that point the frame is evaluated for arm, disarm or a write.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, the arm latch is clear, `cfg_word` and `ctl_word` are 0x0000, every memory byte is 0x00, the lock field is 0 and `miso_oe` is low.
- R2: A frame of exactly 8 clocks carrying opcode 0x06 sets the arm latch when chip select rises.
- R3: A frame of exactly 8 clocks carrying opcode 0x04 clears the arm latch when chip select rises.
- R4: An arm or disarm opcode in a frame of more or fewer than 8 clocks leaves the arm latch unchanged.
- R5: Opcode 0x09 followed by two bytes loads `cfg_word`, and opcode 0x0A followed by two bytes loads `ctl_word`. In both cases the first byte is the upper half.
- R6: A write opcode (0x01, 0x02, 0x09, 0x0A) issued while the arm latch is clear changes no storage.
- R7: The arm latch clears when a write is applied.
- R8: A write frame whose bit count is not exactly its full length (8 per byte) changes no storage and leaves the arm latch as it was.
- R9: Opcode 0x02 is followed by an address high byte, an address low byte and one data byte. It stores the data at the address modulo 512. Opcode 0x03 is followed by two address bytes and then shifts out the stored bytes from that address, moving on to consecutive addresses.
- R10: Opcode 0x01 is followed by one byte, whose low four bits become the lock field. Opcode 0x05 returns the byte {lock[3:0], 0, 0, latch, 0}.
- R11: Opcode 0x0B returns the status byte {000000, latch, 0}, with the arm latch in bit 1.
- R12: `miso_oe` is low while chip select is high, while the opcode and address bytes are being received, for every write frame and for unrecognised opcodes. It is high only in the read-out phase.
- R13: `mosi` is sampled on rising `sck`. Each read bit, most significant bit first, appears on `miso` after one rising edge and before the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the bus master |
| sck | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block; 0 when not enabled |
| miso_oe | output | 1 | High when `miso` should drive the line; low means high impedance |
| cfg_word | output | 16 | Configuration word |
| ctl_word | output | 16 | Control word |

## Verification
The properties assume that `sck` changes far more slowly than `clk`, with at least four system clocks per half period. They also assume that `cs_n` changes only while `sck` is low, so that each rising edge and each deselect is seen exactly once after synchronization. The bench drives every frame through one task. That task holds `sck` low around chip-select edges, changes `mosi` only while `sck` is low, and keeps each half period at four system clocks. The latch and storage properties can therefore count on each frame ending in exactly one `cs_rise` pulse.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LOCK_W = 4;

    typedef enum logic [7:0] {
        OP_LOCK_SET = 8'h01,
        OP_MEM_WR   = 8'h02,
        OP_MEM_RD   = 8'h03,
        OP_DISARM   = 8'h04,
        OP_MEM_STAT = 8'h05,
        OP_ARM      = 8'h06,
        OP_CFG_WR   = 8'h09,
        OP_CTL_WR   = 8'h0A,
        OP_STAT_RD  = 8'h0B
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_PAYLOAD,
        ST_COMPLETE,
        ST_CMD_ONLY,
        ST_READOUT,
        ST_OVERRUN,
        ST_IGNORE
    } state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_s,
    output logic cs_rise,
    output logic sck_rise,
    output logic mosi_s
);
    localparam int PW = 3 * STAGES;

    logic [PW-1:0] pipe_q;
    logic          cs_prev_q;
    logic          sck_prev_q;
    logic          sck_s;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= 3'b100;
                else        pipe_q <= {cs_n, sck, mosi};
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= {STAGES{3'b100}};
                else        pipe_q <= {pipe_q[PW-4:0], cs_n, sck, mosi};
            end
        end
    endgenerate

    assign cs_s   = pipe_q[PW-1];
    assign sck_s  = pipe_q[PW-2];
    assign mosi_s = pipe_q[PW-3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_prev_q  <= cs_s;
            sck_prev_q <= sck_s;
        end
    end

    assign cs_rise  = cs_s & ~cs_prev_q;
    assign sck_rise = sck_s & ~sck_prev_q & ~cs_s;

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_rise,
    input  logic              mosi_s,
    output logic [2:0]        bit_idx,
    output logic              bit_pulse,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [2:0]        cnt_q;
    logic [BYTE_W-2:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shift_q   <= '0;
            bit_pulse <= 1'b0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else if (cs_s) begin
            cnt_q     <= '0;
            bit_pulse <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            bit_pulse <= sck_rise;
            byte_done <= sck_rise && (cnt_q == 3'd7);
            if (sck_rise) begin
                cnt_q   <= cnt_q + 3'd1;
                shift_q <= {shift_q[BYTE_W-3:0], mosi_s};
                if (cnt_q == 3'd7) rx_byte <= {shift_q, mosi_s};
            end
        end
    end

    assign bit_idx = cnt_q;

endmodule

// File: rtl/spi_byte_mem.sv
module spi_byte_mem #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_cmd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_rise,
    input  logic              bit_pulse,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [2:0]        bit_idx,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] ctl_word,
    output logic              wel,
    output logic              commit
);
    state_e            state_q, state_d;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic              more_q;
    logic [LOCK_W-1:0] lock_q;
    logic              wel_q;
    logic              arm_hit, disarm_hit;
    logic [7:0]        rd_byte;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        case (rx_byte)
                            OP_ARM, OP_DISARM:               state_d = ST_CMD_ONLY;
                            OP_MEM_WR, OP_MEM_RD:            state_d = ST_ADDR_HI;
                            OP_CFG_WR, OP_CTL_WR, OP_LOCK_SET: state_d = ST_PAYLOAD;
                            OP_STAT_RD, OP_MEM_STAT:         state_d = ST_READOUT;
                            default:                         state_d = ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR_HI: if (byte_done) state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (byte_done)
                    state_d = (op_q == OP_MEM_RD) ? ST_READOUT : ST_PAYLOAD;
                ST_PAYLOAD: if (byte_done && !more_q) state_d = ST_COMPLETE;
                ST_COMPLETE, ST_CMD_ONLY: if (bit_pulse) state_d = ST_OVERRUN;
                ST_READOUT, ST_OVERRUN, ST_IGNORE: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // frame-end decisions
    assign arm_hit    = cs_rise && (state_q == ST_CMD_ONLY) && (op_q == OP_ARM);
    assign disarm_hit = cs_rise && (state_q == ST_CMD_ONLY) && (op_q == OP_DISARM);
    assign commit     = cs_rise && (state_q == ST_COMPLETE) && wel_q;

    // datapath and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            more_q   <= 1'b0;
            lock_q   <= '0;
            wel_q    <= 1'b0;
            cfg_word <= '0;
            ctl_word <= '0;
        end else begin
            if (byte_done && !cs_s) begin
                unique case (state_q)
                    ST_OPCODE: begin
                        op_q   <= rx_byte;
                        more_q <= (rx_byte == OP_CFG_WR) || (rx_byte == OP_CTL_WR);
                    end
                    ST_ADDR_HI: addr_q <= ADDR_W'({rx_byte, 8'h00});
                    ST_ADDR_LO: addr_q <= addr_q | ADDR_W'(rx_byte);
                    ST_PAYLOAD: begin
                        data_q <= {data_q[WORD_W-BYTE_W-1:0], rx_byte};
                        more_q <= 1'b0;
                    end
                    ST_READOUT: if (op_q == OP_MEM_RD) addr_q <= addr_q + 1'b1;
                    default: ;
                endcase
            end
            if (arm_hit)                    wel_q <= 1'b1;
            else if (disarm_hit || commit)  wel_q <= 1'b0;
            if (commit && op_q == OP_CFG_WR)   cfg_word <= data_q;
            if (commit && op_q == OP_CTL_WR)   ctl_word <= data_q;
            if (commit && op_q == OP_LOCK_SET) lock_q   <= data_q[LOCK_W-1:0];
        end
    end

    // outputs
    always_comb begin
        mem_we    = commit && (op_q == OP_MEM_WR);
        mem_addr  = addr_q;
        mem_wdata = data_q[7:0];
        if (op_q == OP_MEM_RD)        rd_byte = mem_rdata;
        else if (op_q == OP_MEM_STAT) rd_byte = {lock_q, 2'b00, wel_q, 1'b0};
        else                          rd_byte = {6'b0, wel_q, 1'b0};
        miso_oe = (state_q == ST_READOUT);
        miso    = miso_oe ? rd_byte[3'd7 - bit_idx] : 1'b0;
        wel     = wel_q;
    end

endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_cmd_pkg::*;
#(
    parameter int MEM_DEPTH   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] ctl_word
);
    localparam int ADDR_W = $clog2(MEM_DEPTH);

    logic              cs_s, cs_rise, sck_rise, mosi_s;
    logic [2:0]        bit_idx;
    logic              bit_pulse, byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              wel_flag, commit_pulse;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_s(cs_s), .cs_rise(cs_rise), .sck_rise(sck_rise), .mosi_s(mosi_s)
    );

    spi_rx_shift u_rx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_rise(sck_rise), .mosi_s(mosi_s),
        .bit_idx(bit_idx), .bit_pulse(bit_pulse), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    spi_byte_mem #(.DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(mem_addr), .rdata(mem_rdata)
    );

    spi_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise),
        .bit_pulse(bit_pulse), .byte_done(byte_done), .rx_byte(rx_byte),
        .bit_idx(bit_idx), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .miso(miso), .miso_oe(miso_oe), .cfg_word(cfg_word), .ctl_word(ctl_word),
        .wel(wel_flag), .commit(commit_pulse)
    );

endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        cs_rise,
    input logic        miso_oe,
    input logic        wel,
    input logic        commit,
    input logic [15:0] cfg_word,
    input logic [15:0] ctl_word
);
    // R12
    oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);

    // R12
    oe_rises_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> !cs_s);

    // R7
    latch_drops_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !wel);

    // R6
    words_hold_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |=> ($stable(cfg_word) && $stable(ctl_word)));

    // R4
    latch_moves_only_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(wel));

endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .miso_oe(miso_oe),
    .wel(wel_flag), .commit(commit_pulse), .cfg_word(cfg_word), .ctl_word(ctl_word)
);

// File: tb/spi_cmd_decoder_tb.sv
module spi_cmd_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NVEC       = 22;

    typedef struct packed {
        logic [39:0] tx;
        logic [7:0]  nbits;
        logic [7:0]  nrd;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{40'h0B00,       8'd16, 8'd8,  16'h0000, 8'd1},   // R1 latch clear after reset
        '{40'h06,         8'd8,  8'd0,  16'h0000, 8'd2},   // R2 arm
        '{40'h0B00,       8'd16, 8'd8,  16'h0002, 8'd2},   // R2 latch visible
        '{40'h04,         8'd8,  8'd0,  16'h0000, 8'd3},   // R3 disarm
        '{40'h0B00,       8'd16, 8'd8,  16'h0000, 8'd3},   // R3
        '{40'h06,         8'd8,  8'd0,  16'h0000, 8'd9},
        '{40'h020005A5,   8'd32, 8'd0,  16'h0000, 8'd9},   // R9 write 0x005
        '{40'h0B00,       8'd16, 8'd8,  16'h0000, 8'd7},   // R7 latch auto-clear
        '{40'h06,         8'd8,  8'd0,  16'h0000, 8'd9},
        '{40'h0201063C,   8'd32, 8'd0,  16'h0000, 8'd9},   // R9 write 0x106
        '{40'h02000777,   8'd32, 8'd0,  16'h0000, 8'd6},   // R6 unarmed write
        '{40'h0300050000, 8'd40, 8'd16, 16'hA500, 8'd9},   // R9 consecutive read
        '{40'h03010600,   8'd32, 8'd8,  16'h003C, 8'd13},  // R13 read timing
        '{40'h03000700,   8'd32, 8'd8,  16'h0000, 8'd6},   // R6 nothing stored
        '{40'h03030600,   8'd32, 8'd8,  16'h003C, 8'd9},   // R9 address modulo 512
        '{40'h06,         8'd8,  8'd0,  16'h0000, 8'd10},
        '{40'h015B,       8'd16, 8'd0,  16'h0000, 8'd10},  // R10 lock write
        '{40'h0500,       8'd16, 8'd8,  16'h00B0, 8'd10},  // R10 lock readback
        '{40'h06,         8'd8,  8'd0,  16'h0000, 8'd10},
        '{40'h0500,       8'd16, 8'd8,  16'h00B2, 8'd10},  // R10 latch in bit 1
        '{40'h04,         8'd8,  8'd0,  16'h0000, 8'd3},
        '{40'h0B00,       8'd16, 8'd8,  16'h0000, 8'd11}   // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso, miso_oe;
    logic [15:0] cfg_word, ctl_word;
    int          checks = 0;
    int          fails = 0;
    logic [39:0] rx, oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .cfg_word(cfg_word), .ctl_word(ctl_word)
    );

    task automatic chk(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [39:0] tx, input int nbits,
                         output logic [39:0] r, output logic [39:0] o);
        r = '0;
        o = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            r = {r[38:0], miso};
            o = {o[38:0], miso_oe};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic status_is(input logic [7:0] exp, input string req);
        frame(40'h0B00, 16, rx, oe);
        chk(rx[7:0] == exp, req, {32'h0, rx[7:0]}, {32'h0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_word == 16'h0 && ctl_word == 16'h0, "R1 words",
            {8'h0, cfg_word, ctl_word}, 40'h0);
        chk(miso_oe == 1'b0, "R1 oe", {39'h0, miso_oe}, 40'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [39:0] mask;
            frame(VECS[v].tx, int'(VECS[v].nbits), rx, oe);
            mask = (40'd1 << VECS[v].nrd) - 40'd1;
            if (VECS[v].nrd != 0)
                chk((rx & mask) == {24'h0, VECS[v].exp}, $sformatf("R%0d vec%0d", VECS[v].req, v),
                    rx & mask, {24'h0, VECS[v].exp});
            // R12 enable only in read-out bits
            chk((oe & ((40'd1 << VECS[v].nbits) - 40'd1)) == mask,
                $sformatf("R12 vec%0d", v), oe, mask);
        end

        // R5 configuration and control words
        frame(40'h06, 8, rx, oe);
        frame(40'h091234, 24, rx, oe);
        chk(cfg_word == 16'h1234, "R5 cfg", {24'h0, cfg_word}, 40'h1234);
        status_is(8'h00, "R7 after cfg");
        frame(40'h06, 8, rx, oe);
        frame(40'h0AABCD, 24, rx, oe);
        chk(ctl_word == 16'hABCD, "R5 ctl", {24'h0, ctl_word}, 40'hABCD);

        // R6 unarmed configuration write
        frame(40'h09FFFF, 24, rx, oe);
        chk(cfg_word == 16'h1234, "R6 cfg", {24'h0, cfg_word}, 40'h1234);

        // R8 short and long frames
        frame(40'h06, 8, rx, oe);
        frame(40'h09555, 20, rx, oe);
        chk(cfg_word == 16'h1234, "R8 short", {24'h0, cfg_word}, 40'h1234);
        status_is(8'h02, "R8 latch kept");
        frame(40'h12AAAA, 25, rx, oe);
        chk(cfg_word == 16'h1234, "R8 long", {24'h0, cfg_word}, 40'h1234);
        frame(40'h04, 8, rx, oe);

        // R4 arm with wrong bit counts
        frame(40'h00D, 9, rx, oe);
        status_is(8'h00, "R4 nine bits");
        frame(40'h03, 7, rx, oe);
        status_is(8'h00, "R4 seven bits");

        // R12 unrecognised opcode
        frame(40'hFF00, 16, rx, oe);
        chk(oe == 40'h0 && rx == 40'h0, "R12 unknown", oe | rx, 40'h0);

        // R1 reset in mid-run
        frame(40'h06, 8, rx, oe);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_word == 16'h0 && ctl_word == 16'h0, "R1 rerst words",
            {8'h0, cfg_word, ctl_word}, 40'h0);
        status_is(8'h00, "R1 rerst latch");
        frame(40'h03010600, 32, rx, oe);
        chk(rx[7:0] == 8'h00, "R1 rerst mem", {32'h0, rx[7:0]}, 40'h0);
        frame(40'h0500, 16, rx, oe);
        chk(rx[7:0] == 8'h00, "R1 rerst lock", {32'h0, rx[7:0]}, 40'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule